// File: doc/BRIEF.md
# Disk Controller Interrupt and Attention Core

This block is the interrupt and attention core of a disk controller with four drive units. It holds the interrupt-enable, ready, special-condition and transfer-error state of the controller. For every unit it keeps an attention bit, an error-summary bit, an address-error bit and a volume-valid bit. A controller-level fault byte records transfer faults. The host writes control words, a desired cylinder and a desired sector through one write port. It also selects the target unit, supplies a drive-present mask and sets a completion delay counted in clock cycles.

Commands fall into three classes. State functions (no-op, pack acknowledge, drive clear) finish at once and raise nothing. Positioning functions (seek, search) finish through the unit's attention bit after the programmed delay, or at once when the address is out of range. The transfer function (read) drops ready and finishes when the transfer side reports completion, which raises ready again. A single interrupt request goes to the CPU. It is raised on new attention, on a ready rising edge, or by a one-shot software trigger, and it stays up until the CPU acknowledges it.

Top module: `disk_irq_core`

## Requirements
- R1: After reset, rdy=1 and all of the following are 0: ie, irq_req, sc, tre, attn, err_sum, addr_err, vol_valid, fault_byte.
- R2: Register select 0 is the control word: bit0 go, bits3:1 function, bit6 interrupt enable, bit7 ready, bit14 transfer-error clear. A control write copies bit6 into ie. When bit7 is 0, the write requests no interrupt.
- R3: A control write with bit6=1 and bit7=1 while rdy=1 raises irq_req on the next cycle. An irq_ack pulse clears both irq_req and ie.
- R4: Function codes are 0 no-op, 1 pack acknowledge, 2 drive clear, 3 seek, 4 search, 5 read. A command runs only when go=1 and rdy=1. No-op and pack acknowledge raise no attention and no interrupt. Pack acknowledge sets vol_valid of the selected unit.
- R5: A valid seek or search sets attn of the selected unit and sc when it completes. It raises irq_req if ie=1.
- R6: With completion delay N, a valid seek or search issued at clock edge E sets attn at edge E+N+1.
- R7: A seek to a cylinder above MAX_CYL (register select 2) sets addr_err, err_sum and attn of the unit at the very next edge, whatever the delay. Cylinder MAX_CYL itself is valid.
- R8: A search to a sector above MAX_SECT (register select 3), or to an invalid cylinder, raises its error attention at the next edge and ignores the delay.
- R9: Read drops rdy, and later commands are ignored while rdy=0. An xfer_done pulse raises rdy again and requests an interrupt if ie=1, without setting attention.
- R10: Register select 1 clears attention: a 1 in bit k clears attn[k]. sc is 1 exactly while some present unit has attention.
- R11: xfer_fault bits are ORed into fault_byte, and tre is 1 while fault_byte is nonzero. A control write with bit14=1 clears fault_byte.
- R12: Drive clear resets addr_err and err_sum of the selected unit only.
- R13: A command to a unit whose present bit is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 attention clear, 2 cylinder, 3 sector |
| wr_data | input | 16 | Write data |
| unit | input | 2 | Unit targeted by commands |
| present | input | 4 | Drive-present mask |
| cmp_delay | input | 4 | Positioning completion delay in cycles |
| xfer_done | input | 1 | Transfer finished pulse |
| xfer_fault | input | 8 | Transfer fault bits to record |
| irq_ack | input | 1 | CPU took the interrupt |
| irq_req | output | 1 | Interrupt request |
| ie | output | 1 | Interrupt enable |
| rdy | output | 1 | Controller ready |
| sc | output | 1 | Special condition |
| tre | output | 1 | Transfer error |
| fault_byte | output | 8 | Recorded transfer faults |
| attn | output | 4 | Attention per unit |
| err_sum | output | 4 | Error summary per unit |
| addr_err | output | 4 | Invalid address error per unit |
| vol_valid | output | 4 | Volume valid per unit |

## Verification
A wrong completion counter shows up as attn rising one or more cycles early or late, so the bench samples on both sides of edge E+N+1. A stale pending flag or enable bit shows up at irq_req within one cycle of the triggering write, ack or ready edge. Corrupted per-unit state shows up on the neighbouring units' bits right after the command, which the bench reads after each drive clear and each attention clear.

// File: rtl/disk_irq_core.sv
module disk_irq_core #(
  parameter int NUNIT    = 4,
  parameter int CYLW     = 10,
  parameter int SECW     = 5,
  parameter int DLYW     = 4,
  parameter int MAX_CYL  = 814,
  parameter int MAX_SECT = 21,
  localparam int UW      = $clog2(NUNIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [15:0]      wr_data,
  input  logic [UW-1:0]    unit,
  input  logic [NUNIT-1:0] present,
  input  logic [DLYW-1:0]  cmp_delay,
  input  logic             xfer_done,
  input  logic [7:0]       xfer_fault,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic             ie,
  output logic             rdy,
  output logic             sc,
  output logic             tre,
  output logic [7:0]       fault_byte,
  output logic [NUNIT-1:0] attn,
  output logic [NUNIT-1:0] err_sum,
  output logic [NUNIT-1:0] addr_err,
  output logic [NUNIT-1:0] vol_valid
);
  localparam logic [2:0] F_PACK = 3'd1, F_CLR = 3'd2, F_SEEK = 3'd3,
                         F_SRCH = 3'd4, F_READ = 3'd5;

  logic [CYLW-1:0]  cyl_q;
  logic [SECW-1:0]  sec_q;
  logic [DLYW-1:0]  cnt_q [NUNIT];
  logic [NUNIT-1:0] busy_q, done, att_set, att_clr;

  wire             ctl_wr  = wr_en && wr_sel == 2'd0;
  wire  [2:0]      fn      = wr_data[3:1];
  wire             go      = ctl_wr && wr_data[0] && rdy && present[unit];
  wire [NUNIT-1:0] usel    = NUNIT'(1) << unit;
  wire             cyl_bad = cyl_q > CYLW'(MAX_CYL);
  wire             sec_bad = sec_q > SECW'(MAX_SECT);
  wire             pos_cmd = go && (fn == F_SEEK || fn == F_SRCH);
  wire             pos_bad = pos_cmd && (cyl_bad || (fn == F_SRCH && sec_bad));
  wire             pos_go  = pos_cmd && !pos_bad;
  wire             ie_eff  = ctl_wr ? wr_data[6] : ie;
  wire             sw_irq  = ctl_wr && wr_data[6] && wr_data[7] && rdy;
  wire             rdy_up  = !rdy && xfer_done;

  always_comb begin
    for (int u = 0; u < NUNIT; u++) done[u] = busy_q[u] && cnt_q[u] == '0;
    att_set = (done | (pos_bad ? usel : '0)) & present;
    att_clr = (wr_en && wr_sel == 2'd1) ? wr_data[NUNIT-1:0] : '0;
  end

  wire new_att = |(att_set & ~attn);

  assign sc  = |(attn & present);
  assign tre = |fault_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyl_q <= '0; sec_q <= '0; ie <= 1'b0; rdy <= 1'b1; irq_req <= 1'b0;
      fault_byte <= '0; attn <= '0; err_sum <= '0; addr_err <= '0;
      vol_valid <= '0;
    end else begin
      if (wr_en && wr_sel == 2'd2) cyl_q <= wr_data[CYLW-1:0];
      if (wr_en && wr_sel == 2'd3) sec_q <= wr_data[SECW-1:0];
      ie      <= irq_ack ? 1'b0 : ie_eff;
      irq_req <= (irq_req && !irq_ack) || sw_irq || (ie_eff && (new_att || rdy_up));
      if (go && fn == F_READ) rdy <= 1'b0;
      else if (xfer_done)     rdy <= 1'b1;
      fault_byte <= ((ctl_wr && wr_data[14]) ? 8'h00 : fault_byte) | xfer_fault;
      attn <= (attn & ~att_clr) | att_set;
      if (pos_bad) begin
        err_sum  <= err_sum  | usel;
        addr_err <= addr_err | usel;
      end
      if (go && fn == F_CLR) begin
        err_sum  <= err_sum  & ~usel;
        addr_err <= addr_err & ~usel;
      end
      if (go && fn == F_PACK) vol_valid <= vol_valid | usel;
    end
  end

  always_ff @(posedge clk) begin
    for (int u = 0; u < NUNIT; u++) begin
      if (!rst_n) begin
        busy_q[u] <= 1'b0; cnt_q[u] <= '0;
      end else if (pos_go && usel[u]) begin
        busy_q[u] <= 1'b1; cnt_q[u] <= cmp_delay;
      end else if (busy_q[u]) begin
        if (cnt_q[u] == '0) busy_q[u] <= 1'b0;
        else                cnt_q[u]  <= cnt_q[u] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/disk_irq_core_chk.sv
module disk_irq_core_chk #(
  parameter int NUNIT = 4,
  localparam int UW   = $clog2(NUNIT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [15:0]      wr_data,
  input logic [UW-1:0]    unit,
  input logic [NUNIT-1:0] present,
  input logic [7:0]       xfer_fault,
  input logic             irq_ack,
  input logic             irq_req,
  input logic             ie,
  input logic             rdy,
  input logic [7:0]       fault_byte,
  input logic [NUNIT-1:0] attn,
  input logic [NUNIT-1:0] err_sum,
  input logic [NUNIT-1:0] vol_valid
);
  a_r3_ack_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !ie);

  a_r5_attention_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|(attn & present)) && ie) |-> irq_req);

  a_r9_ready_falls_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(wr_en && wr_sel == 2'd0 && wr_data[0] && wr_data[3:1] == 3'd5));

  a_r11_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[14]) |=> fault_byte == $past(xfer_fault));

  a_r4_volume_source: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_valid != $past(vol_valid)) |->
      $past(wr_en && wr_sel == 2'd0 && wr_data[0] && wr_data[3:1] == 3'd1 && rdy && present[unit]));

  a_r12_error_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(err_sum) & ~err_sum)) |->
      $past(wr_en && wr_sel == 2'd0 && wr_data[0] && wr_data[3:1] == 3'd2));
endmodule

bind disk_irq_core disk_irq_core_chk #(.NUNIT(NUNIT)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .unit(unit), .present(present), .xfer_fault(xfer_fault), .irq_ack(irq_ack),
  .irq_req(irq_req), .ie(ie), .rdy(rdy), .fault_byte(fault_byte), .attn(attn),
  .err_sum(err_sum), .vol_valid(vol_valid)
);

// File: tb/test_disk_irq_core.sv
module test_disk_irq_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0; logic [1:0] wr_sel = '0; logic [15:0] wr_data = '0;
  logic [1:0] unit = '0; logic [3:0] present = 4'b0111; logic [3:0] cmp_delay = '0;
  logic xfer_done = 1'b0; logic [7:0] xfer_fault = '0; logic irq_ack = 1'b0;
  logic irq_req, ie, rdy, sc, tre;
  logic [7:0] fault_byte; logic [3:0] attn, err_sum, addr_err, vol_valid;
  int checks = 0, errors = 0;
  bit finished = 0;

  disk_irq_core i_disk_irq_core (.*);

  always #2 clk = ~clk;

  localparam logic [15:0] GO = 16'h0001, IE = 16'h0040, RDYB = 16'h0080, TREB = 16'h4000;
  function automatic logic [15:0] fcode(int f); return 16'(f << 1); endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdy", rdy, 1); chk("R1 ie", ie, 0); chk("R1 irq", irq_req, 0);
    chk("R1 sc", sc, 0); chk("R1 tre", tre, 0); chk("R1 attn", attn, 0);
    chk("R1 vv", vol_valid, 0); chk("R1 err", err_sum | addr_err, 0);
    chk("R1 fault", fault_byte, 0);
  endtask

  task automatic t_ie_only();
    wr(0, IE);
    chk("R2 ie set", ie, 1);
    @(negedge clk); chk("R2 no irq", irq_req, 0);
    wr(0, 0); chk("R2 ie clear", ie, 0);
  endtask

  task automatic t_sw_irq();
    wr(0, IE | RDYB);
    chk("R3 irq", irq_req, 1); chk("R3 ie", ie, 1);
    ack();
    chk("R3 ack irq", irq_req, 0); chk("R3 ack ie", ie, 0);
  endtask

  task automatic t_state_fn();
    unit = 2'd1;
    wr(0, GO | fcode(0) | IE);
    @(negedge clk);
    chk("R4 noop attn", attn, 0); chk("R4 noop irq", irq_req, 0);
    wr(0, GO | fcode(1) | IE);
    @(negedge clk);
    chk("R4 pack vv", vol_valid, 4'b0010); chk("R4 pack attn", attn, 0);
    chk("R4 pack irq", irq_req, 0);
    wr(0, 0);
  endtask

  task automatic t_seek_attn();
    cmp_delay = 0; wr(2, 16'd814); unit = 2'd0;
    wr(0, GO | fcode(3) | IE);
    chk("R6 not yet", attn, 0);
    @(negedge clk);
    chk("R5 attn", attn, 4'b0001); chk("R5 sc", sc, 1); chk("R5 irq", irq_req, 1);
    chk("R7 814 valid", addr_err, 0);
    ack();
    unit = 2'd1; wr(0, GO | fcode(3));
    @(negedge clk);
    chk("R5 attn no ie", attn, 4'b0011); chk("R5 no irq", irq_req, 0);
    wr(1, 16'h0001);
    chk("R10 clear one", attn, 4'b0010); chk("R10 sc stays", sc, 1);
    wr(1, 16'h0002);
    chk("R10 clear all", attn, 0); chk("R10 sc drops", sc, 0);
  endtask

  task automatic t_delay();
    cmp_delay = 4'd3; wr(2, 0); wr(3, 16'd21); unit = 2'd2;
    wr(0, GO | fcode(4));
    repeat (3) @(negedge clk);
    chk("R6 edge E+N", attn, 0);
    @(negedge clk);
    chk("R6 edge E+N+1", attn, 4'b0100); chk("R8 sector 21 valid", addr_err, 0);
    wr(1, 16'h000F);
  endtask

  task automatic t_bad_addr();
    cmp_delay = 4'd5; wr(2, 16'd815); unit = 2'd0;
    wr(0, GO | fcode(3) | IE);
    chk("R7 attn", attn, 4'b0001); chk("R7 aerr", addr_err, 4'b0001);
    chk("R7 esum", err_sum, 4'b0001); chk("R7 irq", irq_req, 1);
    ack(); wr(1, 16'h000F);
    wr(2, 0); wr(3, 16'd22); unit = 2'd1;
    wr(0, GO | fcode(4));
    chk("R8 attn", attn, 4'b0010); chk("R8 aerr", addr_err, 4'b0011);
    wr(0, GO | fcode(2));
    chk("R12 unit1 cleared", err_sum, 4'b0001); chk("R12 aerr", addr_err, 4'b0001);
    unit = 2'd0; wr(0, GO | fcode(2));
    chk("R12 unit0 cleared", err_sum | addr_err, 0);
    wr(1, 16'h000F); cmp_delay = 0;
  endtask

  task automatic t_read();
    unit = 2'd0; wr(0, GO | fcode(5) | IE);
    chk("R9 rdy low", rdy, 0); chk("R9 no irq", irq_req, 0);
    unit = 2'd2; wr(0, GO | fcode(1) | IE);
    chk("R9 ignored while busy", vol_valid, 4'b0010);
    @(negedge clk); xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    chk("R9 rdy back", rdy, 1); chk("R9 irq", irq_req, 1); chk("R9 no attn", attn, 0);
    ack();
  endtask

  task automatic t_fault();
    @(negedge clk); xfer_fault = 8'h30; @(negedge clk); xfer_fault = 8'h00;
    chk("R11 fault", fault_byte, 8'h30); chk("R11 tre", tre, 1);
    wr(0, TREB);
    chk("R11 cleared", fault_byte, 0); chk("R11 tre low", tre, 0);
  endtask

  task automatic t_absent();
    unit = 2'd3; wr(2, 0); wr(0, GO | fcode(3) | IE);
    @(negedge clk); @(negedge clk);
    chk("R13 no attn", attn, 0); chk("R13 no irq", irq_req, 0);
    wr(0, GO | fcode(1));
    chk("R13 no vv", vol_valid, 4'b0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_ie_only(); t_sw_irq(); t_state_fn(); t_seek_attn();
    t_delay(); t_bad_addr(); t_read(); t_fault(); t_absent();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule